// File: doc/BRIEF.md
# Floating-Point System Register Read Unit

This unit executes the instruction that copies one of the floating-point / SIMD system registers into a general-purpose register. It takes a 32-bit instruction word and a flag that says which of two instruction encodings is in use. The conditional encoding carries a condition field. The unconditional encoding always executes. The unit confirms that the word really is this instruction, then applies the condition result and the layered privilege, enable and hypervisor checks. From these it produces exactly one outcome:

- a register-file write,
- a condition-flag update,
- an undefined-instruction strobe, or
- a hypervisor-trap strobe.

The values of the six readable system registers arrive on input ports. The access-control state is supplied as already-resolved control bits. The result is registered and appears one clock after the instruction is presented.

Top module: `fpsr_read_unit`

## Requirements
- R1: An instruction is recognised only when bits 27:21 = 1110111, bit 20 = 1, bits 11:8 = 1010 and bit 4 = 1. With enc_sel = 0, bits 31:28 must also differ from 1111. With enc_sel = 1, bits 31:28 must equal 1110. Any other word produces no output.
- R2: With enc_sel = 0 and cond_pass = 0, a recognised instruction produces no output. With enc_sel = 1, cond_pass is ignored.
- R3: The selector in bits 19:16 chooses the source register, and that value is written to the index in bits 15:12. The mapping is: 0000 identity (r_ident), 0001 status/control (r_status), 0101 feature 2, 0110 feature 1, 0111 feature 0, 1000 exception control (r_exc). Index 13 is a legal destination.
- R4: Rt = 15 with selector 0001 performs no write. It pulses flg_en with flg_nzcv = r_status[31:28].
- R5: Any other selector value, or Rt = 15 with any selector other than 0001, raises undef_o and performs no write.
- R6: At user level (priv_lvl = 0), a read of any register other than status/control raises undef_o. A read of status/control at user level is allowed.
- R7: A status/control read with fpexc_en = 0 raises undef_o. Reads of the other registers ignore fpexc_en.
- R8: When fp_access_ok = 0, every permitted-by-decode read raises undef_o. Otherwise, fp_hyp_trap = 1 raises hyp_trap_o. Both checks take priority over the fpexc_en check, and the user-level check takes priority over both.
- R9: With id_trap_en = 1, an identity-register read from non-secure level 1 that would otherwise succeed raises hyp_trap_o. This trap does not apply in secure state, at level 2, or to other registers.
- R10: Outcomes are registered one cycle after in_valid. At most one of wr_en, flg_en, undef_o and hyp_trap_o is high in any cycle, and all four are low after reset.
- R11: Non-zero values in bits 7:5 and 3:0 do not stop recognition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| enc_sel | input | 1 | 0 = conditional encoding, 1 = unconditional encoding |
| cond_pass | input | 1 | Condition check result |
| priv_lvl | input | 2 | 0 user, 1 kernel, 2 hypervisor |
| nonsecure | input | 1 | Non-secure state |
| fp_access_ok | input | 1 | Coprocessor access controls permit FP use |
| fp_hyp_trap | input | 1 | Hypervisor traps FP use |
| fpexc_en | input | 1 | Enable bit of the exception-control register |
| id_trap_en | input | 1 | Hypervisor identity-register trap control |
| r_ident | input | 32 | Identity register value |
| r_status | input | 32 | Status/control register value |
| r_feat0 | input | 32 | Feature register 0 value |
| r_feat1 | input | 32 | Feature register 1 value |
| r_feat2 | input | 32 | Feature register 2 value |
| r_exc | input | 32 | Exception-control register value |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | 4 | Register-file write index |
| wr_data | output | 32 | Register-file write data |
| flg_en | output | 1 | Condition-flag update strobe |
| flg_nzcv | output | 4 | New N, Z, C, V flags |
| undef_o | output | 1 | Undefined-instruction strobe |
| hyp_trap_o | output | 1 | Hypervisor-trap strobe |

## Verification
The unit is driven with each of the six legal selectors, using distinct register values, so that any wrong source mux leg shows up in the written data. The flags-only destination is exercised both for the status/control register and for the other registers, which separates the flag update from the unpredictable-destination case. The control bits are then swept one at a time, at user, kernel and hypervisor level and in both security states, which shows the order in which undefined and hypervisor-trap outcomes win. Corrupted fixed bits, a cond field of 1111, a failing condition on each encoding, and non-zero reserved bits confirm the boundaries of recognition.

// File: rtl/fpsr_rd_pkg.sv
package fpsr_rd_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;
    localparam int FLG_W  = 4;
    localparam logic [IDX_W-1:0] FLAG_DEST = '1;

    localparam logic [1:0] PL_USER = 2'd0;
    localparam logic [1:0] PL_KERN = 2'd1;

    typedef enum logic [2:0] {
        SRC_IDENT, SRC_STAT, SRC_FEAT2, SRC_FEAT1, SRC_FEAT0, SRC_EXC, SRC_BAD
    } src_e;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_WRITE, ACT_FLAGS, ACT_UNDEF, ACT_HYP
    } act_e;

    typedef struct packed {
        logic             hit;
        src_e             src;
        logic [IDX_W-1:0] rt;
    } dec_t;

    typedef struct packed {
        logic              wr;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic              flg;
        logic [FLG_W-1:0]  nzcv;
        logic              und;
        logic              hyp;
    } res_t;

    function automatic src_e sel_map(input logic [3:0] s);
        case (s)
            4'b0000: return SRC_IDENT;
            4'b0001: return SRC_STAT;
            4'b0101: return SRC_FEAT2;
            4'b0110: return SRC_FEAT1;
            4'b0111: return SRC_FEAT0;
            4'b1000: return SRC_EXC;
            default: return SRC_BAD;
        endcase
    endfunction
endpackage

// File: rtl/fpsr_rd_decode.sv
module fpsr_rd_decode
    import fpsr_rd_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               enc_sel,
    output dec_t               dec
);
    localparam int TOP = INSTR_W - 1;

    logic fixed_ok;
    logic head_ok;

    assign fixed_ok = (instr[27:21] == 7'b1110111) && instr[20]
                   && (instr[11:8] == 4'b1010) && instr[4];

    always_comb begin
        if (enc_sel) head_ok = (instr[TOP-:4] == 4'b1110);
        else         head_ok = (instr[TOP-:4] != 4'b1111);
    end

    assign dec.hit = fixed_ok && head_ok;
    assign dec.src = sel_map(instr[19:16]);
    assign dec.rt  = instr[15:12];
endmodule

// File: rtl/fpsr_rd_gate.sv
module fpsr_rd_gate
    import fpsr_rd_pkg::*;
(
    input  dec_t       dec,
    input  logic       enc_sel,
    input  logic       cond_pass,
    input  logic [1:0] priv_lvl,
    input  logic       nonsecure,
    input  logic       fp_access_ok,
    input  logic       fp_hyp_trap,
    input  logic       fpexc_en,
    input  logic       id_trap_en,
    output act_e       act
);
    logic is_stat;
    assign is_stat = (dec.src == SRC_STAT);

    always_comb begin
        act = ACT_NONE;
        if (!dec.hit || (!enc_sel && !cond_pass)) begin
            act = ACT_NONE;
        end else if (dec.src == SRC_BAD || (dec.rt == FLAG_DEST && !is_stat)) begin
            act = ACT_UNDEF;
        end else if (!is_stat && priv_lvl == PL_USER) begin
            act = ACT_UNDEF;
        end else if (!fp_access_ok) begin
            act = ACT_UNDEF;
        end else if (fp_hyp_trap) begin
            act = ACT_HYP;
        end else if (is_stat && !fpexc_en) begin
            act = ACT_UNDEF;
        end else if (dec.src == SRC_IDENT && id_trap_en && nonsecure
                     && priv_lvl == PL_KERN) begin
            act = ACT_HYP;
        end else if (is_stat && dec.rt == FLAG_DEST) begin
            act = ACT_FLAGS;
        end else begin
            act = ACT_WRITE;
        end
    end
endmodule

// File: rtl/fpsr_rd_mux.sv
module fpsr_rd_mux
    import fpsr_rd_pkg::*;
(
    input  src_e              src,
    input  logic [DATA_W-1:0] r_ident,
    input  logic [DATA_W-1:0] r_status,
    input  logic [DATA_W-1:0] r_feat0,
    input  logic [DATA_W-1:0] r_feat1,
    input  logic [DATA_W-1:0] r_feat2,
    input  logic [DATA_W-1:0] r_exc,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        case (src)
            SRC_IDENT: data = r_ident;
            SRC_STAT:  data = r_status;
            SRC_FEAT2: data = r_feat2;
            SRC_FEAT1: data = r_feat1;
            SRC_FEAT0: data = r_feat0;
            SRC_EXC:   data = r_exc;
            default:   data = '0;
        endcase
    end
endmodule

// File: rtl/fpsr_read_unit.sv
module fpsr_read_unit
    import fpsr_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic              enc_sel,
    input  logic              cond_pass,
    input  logic [1:0]        priv_lvl,
    input  logic              nonsecure,
    input  logic              fp_access_ok,
    input  logic              fp_hyp_trap,
    input  logic              fpexc_en,
    input  logic              id_trap_en,
    input  logic [DATA_W-1:0] r_ident,
    input  logic [DATA_W-1:0] r_status,
    input  logic [DATA_W-1:0] r_feat0,
    input  logic [DATA_W-1:0] r_feat1,
    input  logic [DATA_W-1:0] r_feat2,
    input  logic [DATA_W-1:0] r_exc,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              flg_en,
    output logic [FLG_W-1:0]  flg_nzcv,
    output logic              undef_o,
    output logic              hyp_trap_o
);
    dec_t              dec;
    act_e              act;
    logic [DATA_W-1:0] src_data;
    res_t              nxt;
    res_t              res_q;

    fpsr_rd_decode #(.INSTR_W(32)) u_dec (
        .instr   (instr),
        .enc_sel (enc_sel),
        .dec     (dec)
    );

    fpsr_rd_gate u_gate (
        .dec          (dec),
        .enc_sel      (enc_sel),
        .cond_pass    (cond_pass),
        .priv_lvl     (priv_lvl),
        .nonsecure    (nonsecure),
        .fp_access_ok (fp_access_ok),
        .fp_hyp_trap  (fp_hyp_trap),
        .fpexc_en     (fpexc_en),
        .id_trap_en   (id_trap_en),
        .act          (act)
    );

    fpsr_rd_mux u_mux (
        .src      (dec.src),
        .r_ident  (r_ident),
        .r_status (r_status),
        .r_feat0  (r_feat0),
        .r_feat1  (r_feat1),
        .r_feat2  (r_feat2),
        .r_exc    (r_exc),
        .data     (src_data)
    );

    always_comb begin
        nxt = '0;
        if (in_valid) begin
            nxt.wr   = (act == ACT_WRITE);
            nxt.idx  = (act == ACT_WRITE) ? dec.rt : '0;
            nxt.data = (act == ACT_WRITE) ? src_data : '0;
            nxt.flg  = (act == ACT_FLAGS);
            nxt.nzcv = (act == ACT_FLAGS) ? r_status[DATA_W-1 -: FLG_W] : '0;
            nxt.und  = (act == ACT_UNDEF);
            nxt.hyp  = (act == ACT_HYP);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= nxt;
    end

    assign wr_en      = res_q.wr;
    assign wr_idx     = res_q.idx;
    assign wr_data    = res_q.data;
    assign flg_en     = res_q.flg;
    assign flg_nzcv   = res_q.nzcv;
    assign undef_o    = res_q.und;
    assign hyp_trap_o = res_q.hyp;
endmodule

// File: rtl/fpsr_read_unit_chk.sv
module fpsr_read_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic        enc_sel,
    input logic        cond_pass,
    input logic [1:0]  priv_lvl,
    input logic        fpexc_en,
    input logic [31:0] r_status,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic        flg_en,
    input logic [3:0]  flg_nzcv,
    input logic        undef_o,
    input logic        hyp_trap_o
);
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, flg_en, undef_o, hyp_trap_o}));

    assert_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !(wr_en || flg_en || undef_o || hyp_trap_o));

    assert_cond_fail_R2: assert property (@(posedge clk) disable iff (rst)
        (!enc_sel && !cond_pass) |=> !(wr_en || flg_en || undef_o || hyp_trap_o));

    assert_no_write_r15_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_idx != 4'hF);

    assert_flags_src_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (flg_en |-> (flg_nzcv == $past(r_status[31:28])
                                  && $past(instr[15:12]) == 4'hF)));

    assert_user_write_R6: assert property (@(posedge clk) disable iff (rst)
        (priv_lvl == 2'd0 && instr[19:16] != 4'b0001) |=> !wr_en);

    assert_fpexc_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (!fpexc_en && instr[19:16] == 4'b0001) |=> !(wr_en || flg_en));
endmodule

bind fpsr_read_unit fpsr_read_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .instr      (instr),
    .enc_sel    (enc_sel),
    .cond_pass  (cond_pass),
    .priv_lvl   (priv_lvl),
    .fpexc_en   (fpexc_en),
    .r_status   (r_status),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .flg_en     (flg_en),
    .flg_nzcv   (flg_nzcv),
    .undef_o    (undef_o),
    .hyp_trap_o (hyp_trap_o)
);

// File: tb/sim_fpsr_read_unit.sv
`timescale 1ns/1ps
module sim_fpsr_read_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic        enc_sel, cond_pass;
    logic [1:0]  priv_lvl;
    logic        nonsecure, fp_access_ok, fp_hyp_trap, fpexc_en, id_trap_en;
    logic [31:0] r_ident, r_status, r_feat0, r_feat1, r_feat2, r_exc;
    logic        wr_en, flg_en, undef_o, hyp_trap_o;
    logic [3:0]  wr_idx, flg_nzcv;
    logic [31:0] wr_data;

    int checks = 0;
    int errors = 0;

    // expected outputs, computed from the requirements
    logic        e_wr, e_flg, e_und, e_hyp;
    logic [3:0]  e_idx, e_nzcv;
    logic [31:0] e_data;

    always #2.5 clk = ~clk;

    fpsr_read_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .enc_sel(enc_sel), .cond_pass(cond_pass), .priv_lvl(priv_lvl),
        .nonsecure(nonsecure), .fp_access_ok(fp_access_ok),
        .fp_hyp_trap(fp_hyp_trap), .fpexc_en(fpexc_en), .id_trap_en(id_trap_en),
        .r_ident(r_ident), .r_status(r_status), .r_feat0(r_feat0),
        .r_feat1(r_feat1), .r_feat2(r_feat2), .r_exc(r_exc),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .flg_en(flg_en),
        .flg_nzcv(flg_nzcv), .undef_o(undef_o), .hyp_trap_o(hyp_trap_o)
    );

    function automatic logic [31:0] mk(input logic [3:0] head, input logic [3:0] sel,
                                       input logic [3:0] rt, input logic [6:0] sbz);
        return {head, 7'b1110111, 1'b1, sel, rt, 4'b1010, sbz[6:4], 1'b1, sbz[3:0]};
    endfunction

    task automatic model();
        logic ok;
        int   s;
        e_wr = 0; e_flg = 0; e_und = 0; e_hyp = 0;
        e_idx = 0; e_nzcv = 0; e_data = 0;
        s = instr[19:16];
        ok = in_valid && instr[27:21] == 7'h77 && instr[20] && instr[11:8] == 4'hA && instr[4];
        if (enc_sel) ok = ok && instr[31:28] == 4'hE;
        else         ok = ok && instr[31:28] != 4'hF && cond_pass;
        if (!ok) return;
        if (!(s inside {0, 1, 5, 6, 7, 8}) || (instr[15:12] == 15 && s != 1)) begin
            e_und = 1; return;
        end
        if (s != 1 && priv_lvl == 0) begin e_und = 1; return; end
        if (!fp_access_ok) begin e_und = 1; return; end
        if (fp_hyp_trap) begin e_hyp = 1; return; end
        if (s == 1 && !fpexc_en) begin e_und = 1; return; end
        if (s == 0 && id_trap_en && nonsecure && priv_lvl == 1) begin e_hyp = 1; return; end
        if (s == 1 && instr[15:12] == 15) begin
            e_flg = 1; e_nzcv = r_status[31:28]; return;
        end
        e_wr = 1; e_idx = instr[15:12];
        case (s)
            0: e_data = r_ident;
            1: e_data = r_status;
            5: e_data = r_feat2;
            6: e_data = r_feat1;
            7: e_data = r_feat0;
            default: e_data = r_exc;
        endcase
    endtask

    task automatic compare(input string tag);
        logic bad;
        bad = (wr_en !== e_wr) || (flg_en !== e_flg) || (undef_o !== e_und)
           || (hyp_trap_o !== e_hyp)
           || (e_wr && (wr_idx !== e_idx || wr_data !== e_data))
           || (e_flg && flg_nzcv !== e_nzcv);
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s: got wr=%b idx=%0d data=%h flg=%b nzcv=%b und=%b hyp=%b exp wr=%b idx=%0d data=%h flg=%b nzcv=%b und=%b hyp=%b",
                     tag, wr_en, wr_idx, wr_data, flg_en, flg_nzcv, undef_o, hyp_trap_o,
                     e_wr, e_idx, e_data, e_flg, e_nzcv, e_und, e_hyp);
        end
    endtask

    // drive at negedge, result registered at next posedge, sample at the following negedge
    task automatic step(input logic [31:0] w, input string tag);
        in_valid = 1'b1;
        instr = w;
        model();
        @(negedge clk);
        compare(tag);
        in_valid = 1'b0;
    endtask

    task automatic defaults();
        enc_sel = 0; cond_pass = 1; priv_lvl = 1; nonsecure = 1;
        fp_access_ok = 1; fp_hyp_trap = 0; fpexc_en = 1; id_trap_en = 0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; in_valid = 0; instr = 0;
        defaults();
        r_ident = 32'h4102_30A1; r_status = 32'hA000_0013; r_feat0 = 32'h1011_0222;
        r_feat1 = 32'h1211_1111; r_feat2 = 32'h0000_0043; r_exc = 32'h4000_0700;
        repeat (3) @(negedge clk);
        rst = 0;
        e_wr = 0; e_flg = 0; e_und = 0; e_hyp = 0; e_idx = 0; e_nzcv = 0; e_data = 0;
        compare("R10 reset");

        // R3 every selector, kernel level
        step(mk(4'hE, 4'b0000, 4'd2, 0), "R3 ident");
        step(mk(4'h0, 4'b0001, 4'd3, 0), "R3 status");
        step(mk(4'hE, 4'b0101, 4'd4, 0), "R3 feat2");
        step(mk(4'hE, 4'b0110, 4'd5, 0), "R3 feat1");
        step(mk(4'hE, 4'b0111, 4'd13, 0), "R3 feat0 rt13");
        step(mk(4'hE, 4'b1000, 4'd0, 0), "R3 exc");
        enc_sel = 1;
        step(mk(4'hE, 4'b0111, 4'd7, 0), "R3 unconditional");
        enc_sel = 0;

        // R4 flags
        step(mk(4'hE, 4'b0001, 4'hF, 0), "R4 flags");
        r_status = 32'h5000_0000;
        step(mk(4'hE, 4'b0001, 4'hF, 0), "R4 flags other");

        // R5 unpredictable cases
        step(mk(4'hE, 4'b0010, 4'd1, 0), "R5 sel0010");
        step(mk(4'hE, 4'b1111, 4'd1, 0), "R5 sel1111");
        step(mk(4'hE, 4'b0000, 4'hF, 0), "R5 rt15 ident");

        // R1 recognition
        step(mk(4'hF, 4'b0001, 4'd1, 0), "R1 cond1111");
        step(mk(4'hE, 4'b0001, 4'd1, 0) ^ 32'h0000_0100, "R1 bad bit8");
        step(mk(4'hE, 4'b0001, 4'd1, 0) ^ 32'h0010_0000, "R1 bad bit20");
        enc_sel = 1;
        step(mk(4'h0, 4'b0001, 4'd1, 0), "R1 unconditional head");
        enc_sel = 0;

        // R2 condition
        cond_pass = 0;
        step(mk(4'h1, 4'b0001, 4'd1, 0), "R2 cond fail");
        enc_sel = 1;
        step(mk(4'hE, 4'b0001, 4'd1, 0), "R2 unconditional ignores");
        defaults();

        // R11 reserved bits
        step(mk(4'hE, 4'b0110, 4'd6, 7'h7F), "R11 sbz set");

        // R6 user level
        priv_lvl = 0;
        step(mk(4'hE, 4'b1000, 4'd1, 0), "R6 user exc");
        step(mk(4'hE, 4'b0001, 4'd1, 0), "R6 user status");
        fp_hyp_trap = 1;
        step(mk(4'hE, 4'b0000, 4'd1, 0), "R6 user beats hyp");
        defaults();

        // R7 fpexc enable
        fpexc_en = 0;
        step(mk(4'hE, 4'b0001, 4'd1, 0), "R7 status off");
        step(mk(4'hE, 4'b0001, 4'hF, 0), "R7 flags off");
        step(mk(4'hE, 4'b1000, 4'd1, 0), "R7 exc ignores");
        defaults();

        // R8 access controls
        fp_access_ok = 0;
        step(mk(4'hE, 4'b0111, 4'd1, 0), "R8 deny");
        fp_access_ok = 1; fp_hyp_trap = 1;
        step(mk(4'hE, 4'b0111, 4'd1, 0), "R8 hyp trap");
        fpexc_en = 0;
        step(mk(4'hE, 4'b0001, 4'd1, 0), "R8 hyp beats fpexc");
        defaults();

        // R9 identity trap
        id_trap_en = 1;
        step(mk(4'hE, 4'b0000, 4'd1, 0), "R9 trap");
        step(mk(4'hE, 4'b0101, 4'd1, 0), "R9 other reg");
        nonsecure = 0;
        step(mk(4'hE, 4'b0000, 4'd1, 0), "R9 secure");
        nonsecure = 1; priv_lvl = 2;
        step(mk(4'hE, 4'b0000, 4'd1, 0), "R9 level2");
        defaults();

        // R10 idle cycle
        model();
        @(negedge clk);
        compare("R10 idle");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule